// File: doc/BRIEF.md
# Guarded Endian-Selectable Word Store Stage

This block is the store stage that turns one 32-bit word store request into a single lane-arranged write toward byte-addressed data memory. The effective address is a base register plus a 7-bit signed displacement. The displacement is scaled by four, so it reaches any word from -256 to +252 bytes around the base. A per-request mode bit selects the byte order. Stores aimed at the memory-mapped I/O aperture always use big-endian lane order, whatever that bit says.

A store is predicated by a guard operand, and only bit 0 of the guard is looked at. When that bit is 0 the request leaves no trace: there is no write strobe and no status change. If an enabled store computes an address that is not word aligned, the write is issued with every byte enable low. The same store also sets a sticky misaligned-store flag. While the flag is set and trapping is enabled, an exception request is held high for the core's exception logic to take at its next interruptible jump.

The stage is one register deep. Its results appear on the outputs in the cycle after the clock edge that accepts the request.

Top module: `word_store_unit`

## Requirements
- R1: For an accepted store (req_vld_i=1 and guard_i[0]=1), wr_vld_o is 1 one cycle later. In that cycle wr_addr_o equals (base_i + sign_extend(disp_i)*4) with bits 1:0 forced to 0.
- R2: With big-endian order (order_le_i=0), the byte at address offset k is placed on wr_data_o[8k+7:8k]. Offset 0 carries data_i[31:24], offset 1 carries [23:16], offset 2 carries [15:8] and offset 3 carries [7:0]. An aligned store drives wr_be_o=4'b1111.
- R3: With little-endian order (order_le_i=1) and mmio_i=0, offset 0 carries data_i[7:0] and offset 3 carries data_i[31:24], so wr_data_o equals data_i.
- R4: If the effective address has non-zero bits 1:0, the store still pulses wr_vld_o but with wr_be_o=4'b0000. mis_flag_o is 1 in the following cycle, even if flag_clr_i is high in the same cycle.
- R5: mis_flag_o is sticky. An aligned store does not clear it. Only flag_clr_i=1 with no misaligned store in the same cycle clears it, and the flag reads 0 in the next cycle.
- R6: exc_req_o is 1 exactly when mis_flag_o is 1 and trap_en_i is 1.
- R7: When guard_i[0]=0, wr_vld_o and wr_be_o stay 0 and mis_flag_o keeps its value. This holds for a misaligned address and for any value of guard_i[31:1].
- R8: When mmio_i=1, the lanes follow the big-endian mapping of R2 regardless of order_le_i.
- R9: After reset, wr_vld_o=0, wr_be_o=0 and mis_flag_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_vld_i | input | 1 | Store request present this cycle |
| guard_i | input | 32 | Guard operand; only bit 0 is used |
| base_i | input | 32 | Base address register |
| data_i | input | 32 | Word to be stored |
| disp_i | input | 7 | Signed displacement in words |
| order_le_i | input | 1 | 1 = little-endian, 0 = big-endian |
| trap_en_i | input | 1 | Trap on misaligned store enable |
| mmio_i | input | 1 | Address lies in the I/O aperture |
| flag_clr_i | input | 1 | Clears the misaligned flag |
| wr_vld_o | output | 1 | Write strobe |
| wr_addr_o | output | 32 | Word-aligned write address |
| wr_be_o | output | 4 | Byte enables, bit k for offset k |
| wr_data_o | output | 32 | Lane-arranged write data |
| mis_flag_o | output | 1 | Sticky misaligned-store flag |
| exc_req_o | output | 1 | Exception request |

## Verification
The hardest situations to reach are the ones where the flag's history matters. Examples are a misaligned store that collides with a clear request, or a predicated-off misaligned store arriving after the flag was just cleared. Directed sequences first set the flag with a misaligned base. They then issue an aligned store, clear the flag, and send a guard-false misaligned store. The flag is sampled after each step. A final step drives a misaligned store and a clear in the same cycle. The signed displacement extremes (-64 and +63 words) sit in the vector table so that both carry directions of the address adder are exercised.

// File: rtl/word_store_unit.sv
module word_store_unit #(
  parameter int AW     = 32,
  parameter int GW     = 32,
  parameter int DISP_W = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_vld_i,
  input  logic [GW-1:0] guard_i,
  input  logic [AW-1:0] base_i,
  input  logic [31:0]   data_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic          order_le_i,
  input  logic          trap_en_i,
  input  logic          mmio_i,
  input  logic          flag_clr_i,
  output logic          wr_vld_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [3:0]    wr_be_o,
  output logic [31:0]   wr_data_o,
  output logic          mis_flag_o,
  output logic          exc_req_o
);
  localparam int SCALE = 2;
  localparam int EXT_W = AW - DISP_W - SCALE;

  logic [AW-1:0] disp_ext, ea;
  logic          go, misal, use_le;
  logic [31:0]   lanes;

  assign disp_ext = {{EXT_W{disp_i[DISP_W-1]}}, disp_i, {SCALE{1'b0}}};
  assign ea       = base_i + disp_ext;
  assign go       = req_vld_i & guard_i[0];
  assign misal    = |ea[SCALE-1:0];
  assign use_le   = order_le_i & ~mmio_i;
  assign lanes    = use_le ? data_i
                           : {data_i[7:0], data_i[15:8], data_i[23:16], data_i[31:24]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_vld_o   <= 1'b0;
      wr_addr_o  <= '0;
      wr_be_o    <= 4'b0000;
      wr_data_o  <= '0;
      mis_flag_o <= 1'b0;
    end else begin
      wr_vld_o <= go;
      wr_be_o  <= (go && !misal) ? 4'b1111 : 4'b0000;
      if (go) begin
        wr_addr_o <= {ea[AW-1:SCALE], {SCALE{1'b0}}};
        wr_data_o <= lanes;
      end
      if (go && misal)  mis_flag_o <= 1'b1;
      else if (flag_clr_i) mis_flag_o <= 1'b0;
    end
  end

  assign exc_req_o = mis_flag_o & trap_en_i;

  a_r1_addr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    wr_vld_o |-> (wr_addr_o[1:0] == 2'b00));
  a_r4_be_all_or_none: assert property (@(posedge clk) disable iff (!rst_n)
    wr_be_o != 4'b0000 |-> (wr_be_o == 4'b1111 && wr_vld_o));
  a_r4_flag_rise_blank: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mis_flag_o) |-> (wr_vld_o && wr_be_o == 4'b0000));
  a_r4_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    (go && misal) |=> mis_flag_o);
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (mis_flag_o && !flag_clr_i) |=> mis_flag_o);
  a_r6_exc_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req_o |-> (mis_flag_o && trap_en_i));
  a_r7_guard_false: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld_i && !guard_i[0]) |=> (!wr_vld_o && $stable(mis_flag_o)));
endmodule

// File: tb/word_store_unit_tb_top.sv
module word_store_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_vld_i = 1'b0;
  logic [31:0] guard_i = '0;
  logic [31:0] base_i = '0;
  logic [31:0] data_i = '0;
  logic [6:0]  disp_i = '0;
  logic        order_le_i = 1'b0, trap_en_i = 1'b0, mmio_i = 1'b0, flag_clr_i = 1'b0;
  logic        wr_vld_o, mis_flag_o, exc_req_o;
  logic [31:0] wr_addr_o, wr_data_o;
  logic [3:0]  wr_be_o;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  word_store_unit dut_i (.*);

  typedef struct packed {
    logic        le; logic mm; logic g;
    logic [31:0] base; logic [6:0] disp; logic [31:0] data;
    logic        evld; logic [31:0] eaddr; logic [31:0] edata;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 1'b1, 32'h0000_0CFC, 7'h01, 32'h4433_2211, 1'b1, 32'h0000_0D00, 32'h1122_3344},
    '{1'b1, 1'b0, 1'b1, 32'h0000_0CFC, 7'h01, 32'h4433_2211, 1'b1, 32'h0000_0D00, 32'h4433_2211},
    '{1'b0, 1'b0, 1'b1, 32'h0000_0D0C, 7'h7E, 32'hAABB_CCDD, 1'b1, 32'h0000_0D04, 32'hDDCC_BBAA},
    '{1'b0, 1'b0, 1'b0, 32'h0000_0D0C, 7'h7E, 32'hAABB_CCDD, 1'b0, 32'h0,         32'h0},
    '{1'b1, 1'b1, 1'b1, 32'h0000_1000, 7'h00, 32'h0102_0304, 1'b1, 32'h0000_1000, 32'h0403_0201},
    '{1'b0, 1'b1, 1'b1, 32'h0000_1000, 7'h00, 32'h0102_0304, 1'b1, 32'h0000_1000, 32'h0403_0201},
    '{1'b1, 1'b0, 1'b1, 32'h0000_0200, 7'h40, 32'hCAFE_F00D, 1'b1, 32'h0000_0100, 32'hCAFE_F00D},
    '{1'b0, 1'b0, 1'b1, 32'h0000_0000, 7'h3F, 32'h1234_5678, 1'b1, 32'h0000_00FC, 32'h7856_3412}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic store(input logic g0, input logic [31:0] g, input logic [31:0] b,
                       input logic [6:0] d, input logic [31:0] w, input logic le,
                       input logic mm, input logic clr);
    @(negedge clk);
    req_vld_i = g0; guard_i = g; base_i = b; disp_i = d; data_i = w;
    order_le_i = le; mmio_i = mm; flag_clr_i = clr;
    @(negedge clk);
    req_vld_i = 1'b0; flag_clr_i = 1'b0;
  endtask

  initial begin
    #400000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1;
    check("R9 vld", {31'b0, wr_vld_o}, 32'h0);
    check("R9 be", {28'b0, wr_be_o}, 32'h0);
    check("R9 flag", {31'b0, mis_flag_o}, 32'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      store(1'b1, {31'b0, VEC[i].g}, VEC[i].base, VEC[i].disp, VEC[i].data,
            VEC[i].le, VEC[i].mm, 1'b0);
      check($sformatf("R1 vld vec%0d", i), {31'b0, wr_vld_o}, {31'b0, VEC[i].evld});
      if (VEC[i].evld) begin
        check($sformatf("R1 addr vec%0d", i), wr_addr_o, VEC[i].eaddr);
        check($sformatf("R2/R3/R8 data vec%0d", i), wr_data_o, VEC[i].edata);
        check($sformatf("R2 be vec%0d", i), {28'b0, wr_be_o}, 32'hF);
      end else begin
        check($sformatf("R7 be vec%0d", i), {28'b0, wr_be_o}, 32'h0);
      end
    end
    check("R7 flag untouched", {31'b0, mis_flag_o}, 32'h0);

    // R7: upper guard bits set, bit 0 clear, misaligned address
    store(1'b1, 32'hFFFF_FFFE, 32'h0000_0D0B, 7'h7E, 32'h1, 1'b0, 1'b0, 1'b0);
    check("R7 upper guard vld", {31'b0, wr_vld_o}, 32'h0);
    check("R7 upper guard flag", {31'b0, mis_flag_o}, 32'h0);

    // R4: misaligned store, D0B - 8 = D03
    trap_en_i = 1'b0;
    store(1'b1, 32'h1, 32'h0000_0D0B, 7'h7E, 32'hAABB_CCDD, 1'b0, 1'b0, 1'b0);
    check("R4 vld", {31'b0, wr_vld_o}, 32'h1);
    check("R4 be", {28'b0, wr_be_o}, 32'h0);
    check("R4 flag", {31'b0, mis_flag_o}, 32'h1);
    check("R6 no trap", {31'b0, exc_req_o}, 32'h0);
    trap_en_i = 1'b1; #1;
    check("R6 trap", {31'b0, exc_req_o}, 32'h1);

    // R5: aligned store keeps flag
    store(1'b1, 32'h1, 32'h0000_0100, 7'h00, 32'h5, 1'b0, 1'b0, 1'b0);
    check("R5 sticky", {31'b0, mis_flag_o}, 32'h1);
    check("R5 aligned be", {28'b0, wr_be_o}, 32'hF);
    store(1'b0, 32'h0, 32'h0, 7'h0, 32'h0, 1'b0, 1'b0, 1'b1);
    check("R5 clear", {31'b0, mis_flag_o}, 32'h0);
    check("R6 trap off after clear", {31'b0, exc_req_o}, 32'h0);

    // R7: guard-false misaligned after clear
    store(1'b1, 32'h0, 32'h0000_0002, 7'h00, 32'h0, 1'b0, 1'b0, 1'b0);
    check("R7 misal guard false", {31'b0, mis_flag_o}, 32'h0);

    // R4: set wins over clear in the same cycle
    store(1'b1, 32'h1, 32'h0000_0001, 7'h00, 32'h0, 1'b1, 1'b0, 1'b1);
    check("R4 set over clear", {31'b0, mis_flag_o}, 32'h1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule